// File: doc/BRIEF.md
# Frame-Buffer Bit Array with Serial Row Streamer

This block holds a one-bit-per-pixel frame buffer as a square array of cells, 256 rows by 256 columns by default. A random-access port reads and writes any single cell. The same side of the block can also start a rectangle fill. The fill sequencer then walks a region one cell per cycle and stores a chosen value, 0 or 1, in every cell of that region.

A second, independent side serves display refresh. A transfer request copies one whole row, in a single operation, into a row-wide shift register. The register then streams that row out one bit at a time. A clock enable from the video side acts as the ready signal of the stream. Random accesses and fills carry on while the stream drains.

The pixel stream is a valid/ready interface. `pix_valid` stays high while captured bits remain. A bit leaves the register only on a cycle where both `pix_valid` and `pix_ready` are high. While `pix_ready` is low, `pix_data` holds its bit. The random port uses `ra_valid`/`ra_ready`. A request is taken only on a cycle where both are high. `ra_ready` drops for as long as a fill runs.

Top module: `fbuf_vram`

## Requirements
- R1: After reset, `pix_valid` is 0, `ser_empty` is 1, `fill_busy` is 0, `rd_valid` is 0 and `ra_ready` is 1.
- R2: An accepted write (`ra_we`=1) stores `ra_wdata` at (`ra_row`, `ra_col`). An accepted read (`ra_we`=0) raises `rd_valid` on the following cycle, with `rd_data` equal to that cell.
- R3: A `xfer_req` sampled at clock edge k loads the row `xfer_row` at edge k+1. From then on, `pix_valid` is 1 and `pix_data` presents column 0 first, then each higher column in turn.
- R4: Once all columns of the row have been handed over, `pix_valid` is 0 and `ser_empty` is 1. Both stay that way until the next transfer loads a row.
- R5: A write to the loaded row on the load edge, or on any later edge, does not change the bits that are streamed.
- R6: A fill with corners (`fill_x0`,`fill_y0`) and (`fill_x1`,`fill_y1`), both inclusive and given in either order, sets every cell of that rectangle to `fill_value`. It leaves every other cell as it was.
- R7: A fill stores one cell per cycle, in row-major order (column inner, row outer). `fill_busy` is high from the edge that samples `fill_start`. For a region of N cells with no transfers, `fill_done` is high for exactly one cycle, N edges after the start edge, and `fill_busy` falls on that same edge.
- R8: A transfer that arrives during a fill takes the next cycle. The fill makes no step on that cycle, so its run grows by one cycle per transfer. The loaded row holds every fill store made before the load edge.
- R9: While `fill_busy` is 1, `ra_ready` is 0. A random request offered then has no effect, and a new `fill_start` is ignored.
- R10: While `pix_valid` is 1 and `pix_ready` is 0, `pix_data` and the stream position do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_valid | input | 1 | Random-access request valid |
| ra_ready | output | 1 | Random port can accept (low during a fill) |
| ra_we | input | 1 | 1 = write, 0 = read |
| ra_row | input | ROW_W | Row of the cell |
| ra_col | input | COL_W | Column of the cell |
| ra_wdata | input | 1 | Bit to write |
| rd_valid | output | 1 | Read data valid, one cycle after acceptance |
| rd_data | output | 1 | Read bit |
| fill_start | input | 1 | Start a rectangle fill (ignored while busy) |
| fill_x0 | input | COL_W | First corner column |
| fill_y0 | input | ROW_W | First corner row |
| fill_x1 | input | COL_W | Second corner column |
| fill_y1 | input | ROW_W | Second corner row |
| fill_value | input | 1 | Value stored in the region |
| fill_busy | output | 1 | Fill in progress |
| fill_done | output | 1 | One-cycle pulse when the fill ends |
| xfer_req | input | 1 | Load a row into the serial register |
| xfer_row | input | ROW_W | Row to load |
| pix_valid | output | 1 | Serial bit available |
| pix_ready | input | 1 | Video clock enable; consumes one bit |
| pix_data | output | 1 | Current serial bit |
| ser_empty | output | 1 | Serial register drained |

## Verification
Two collisions are provoked on purpose.

In the first, a transfer lands mid-fill. The bench raises `xfer_req` a set number of cycles after a fill starts. It then checks three things: the fill takes exactly one extra cycle, the fill does not lose a cell, and the streamed row matches a prefix of the row-major fill order of known length.

In the second, a random write hits the loaded row on the load edge itself and on every streaming cycle. The bench writes the inverse of each bit just before it is due. The stream must still show the old row, and a later readback must show the new bits.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/fbuf_bitarray.sv
module fbuf_bitarray #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ROW_W-1:0]   w_row,
  input  logic [COL_W-1:0]   w_col,
  input  logic               w_bit,
  input  logic               rd_en,
  input  logic [ROW_W-1:0]   rd_row,
  input  logic [COL_W-1:0]   rd_col,
  output logic               rd_bit,
  output logic               rd_vld,
  input  logic [ROW_W-1:0]   xr_row,
  output logic [(1<<COL_W)-1:0] xr_word
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  // one row-wide word per row, so a whole row can be copied in one cycle
  logic [COLS-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[w_row][w_col] <= w_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_bit <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_bit <= cells[rd_row][rd_col];
    end
  end

  // combinational row tap; the shifter registers it
  assign xr_word = cells[xr_row];
endmodule

// File: rtl/fbuf_fill_seq.sv
module fbuf_fill_seq
  import fbuf_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] x0,
  input  logic [ROW_W-1:0] y0,
  input  logic [COL_W-1:0] x1,
  input  logic [ROW_W-1:0] y1,
  input  logic             val,
  input  logic             stall,
  output logic             busy,
  output logic             done,
  output logic             we,
  output logic [ROW_W-1:0] w_row,
  output logic [COL_W-1:0] w_col,
  output logic             w_bit
);
  fill_state_e      st;
  logic [COL_W-1:0] xs, xe, x;
  logic [ROW_W-1:0] ye, y;
  logic             v;

  assign busy  = (st == FS_RUN);
  assign we    = busy && !stall;
  assign w_row = y;
  assign w_col = x;
  assign w_bit = v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= FS_IDLE;
      done <= 1'b0;
      xs   <= '0;
      xe   <= '0;
      x    <= '0;
      ye   <= '0;
      y    <= '0;
      v    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == FS_IDLE) begin
        if (start) begin
          // corners may arrive in any order: sort them here
          xs <= (x0 <= x1) ? x0 : x1;
          x  <= (x0 <= x1) ? x0 : x1;
          xe <= (x0 <= x1) ? x1 : x0;
          y  <= (y0 <= y1) ? y0 : y1;
          ye <= (y0 <= y1) ? y1 : y0;
          v  <= val;
          st <= FS_RUN;
        end
      end else if (!stall) begin
        if (x == xe) begin
          x <= xs;
          if (y == ye) begin
            st   <= FS_IDLE;
            done <= 1'b1;
          end else begin
            y <= y + 1'b1;
          end
        end else begin
          x <= x + 1'b1;
        end
      end
    end
  end

  AST_FILL_HOLDS_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stall) |=> ($stable(x) && $stable(y) && busy)); // R8
  AST_FILL_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_FILL_INSIDE_RECT: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (x >= xs && x <= xe && y <= ye)); // R6
  AST_FILL_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
endmodule

// File: rtl/fbuf_row_shifter.sv
module fbuf_row_shifter #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer_req,
  input  logic [ROW_W-1:0]      xfer_row,
  output logic                  pend,
  output logic [ROW_W-1:0]      ld_row,
  input  logic [(1<<COL_W)-1:0] row_word,
  input  logic                  pix_ready,
  output logic                  pix_valid,
  output logic                  pix_data,
  output logic                  empty
);
  localparam int COLS = 1 << COL_W;
  localparam logic [COL_W:0] FULL = COLS[COL_W:0];

  logic [COLS-1:0] sh;
  logic [COL_W:0]  cnt;

  assign pix_valid = (cnt != '0);
  assign empty     = (cnt == '0);
  assign pix_data  = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      ld_row <= '0;
      sh     <= '0;
      cnt    <= '0;
    end else begin
      // request is registered: the current fill store lands first
      pend <= xfer_req;
      if (xfer_req) ld_row <= xfer_row;
      if (pend) begin
        sh  <= row_word;
        cnt <= FULL;
      end else if (pix_valid && pix_ready) begin
        sh  <= {1'b0, sh[COLS-1:1]};
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (cnt == FULL)); // R3
  AST_LAST_BIT_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 1 && pix_ready && !pend) |=> empty); // R4
  AST_EMPTY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !pend) |=> empty); // R4
  AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_ready && !pend) |=> ($stable(pix_data) && $stable(cnt))); // R10
endmodule

// File: rtl/fbuf_vram.sv
module fbuf_vram
  import fbuf_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ra_valid,
  output logic             ra_ready,
  input  logic             ra_we,
  input  logic [ROW_W-1:0] ra_row,
  input  logic [COL_W-1:0] ra_col,
  input  logic             ra_wdata,
  output logic             rd_valid,
  output logic             rd_data,
  input  logic             fill_start,
  input  logic [COL_W-1:0] fill_x0,
  input  logic [ROW_W-1:0] fill_y0,
  input  logic [COL_W-1:0] fill_x1,
  input  logic [ROW_W-1:0] fill_y1,
  input  logic             fill_value,
  output logic             fill_busy,
  output logic             fill_done,
  input  logic             xfer_req,
  input  logic [ROW_W-1:0] xfer_row,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic             pix_data,
  output logic             ser_empty
);
  localparam int COLS = 1 << COL_W;

  logic             acc, ra_wr, ra_rd;
  logic             f_we, f_bit;
  logic [ROW_W-1:0] f_row;
  logic [COL_W-1:0] f_col;
  logic             a_we, a_bit;
  logic [ROW_W-1:0] a_row;
  logic [COL_W-1:0] a_col;
  logic             ld_pend;
  logic [ROW_W-1:0] ld_row;
  logic [COLS-1:0]  row_word;

  assign ra_ready = !fill_busy;
  assign acc      = ra_valid && ra_ready;
  assign ra_wr    = acc && ra_we;
  assign ra_rd    = acc && !ra_we;

  // single write port: the fill owns it while busy, the random port otherwise
  assign a_we  = f_we || ra_wr;
  assign a_row = f_we ? f_row : ra_row;
  assign a_col = f_we ? f_col : ra_col;
  assign a_bit = f_we ? f_bit : ra_wdata;

  fbuf_fill_seq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_fill (
    .clk(clk), .rst_n(rst_n), .start(fill_start),
    .x0(fill_x0), .y0(fill_y0), .x1(fill_x1), .y1(fill_y1), .val(fill_value),
    .stall(ld_pend), .busy(fill_busy), .done(fill_done),
    .we(f_we), .w_row(f_row), .w_col(f_col), .w_bit(f_bit)
  );

  fbuf_bitarray #(.ROW_W(ROW_W), .COL_W(COL_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .we(a_we), .w_row(a_row), .w_col(a_col), .w_bit(a_bit),
    .rd_en(ra_rd), .rd_row(ra_row), .rd_col(ra_col),
    .rd_bit(rd_data), .rd_vld(rd_valid),
    .xr_row(ld_row), .xr_word(row_word)
  );

  fbuf_row_shifter #(.ROW_W(ROW_W), .COL_W(COL_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .pend(ld_pend), .ld_row(ld_row), .row_word(row_word),
    .pix_ready(pix_ready), .pix_valid(pix_valid), .pix_data(pix_data),
    .empty(ser_empty)
  );

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_we && ra_wr)); // R9
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_valid && ra_ready && !ra_we) |=> rd_valid); // R2
  AST_NO_READ_WHILE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_busy && !ra_we) |=> !rd_valid); // R9
endmodule

// File: tb/sim_fbuf_vram.sv
`timescale 1ns/1ps
module sim_fbuf_vram;
  localparam int RW = 3;
  localparam int CW = 4;
  localparam int ROWS = 1 << RW;
  localparam int COLS = 1 << CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ra_valid = 0, ra_we = 0, ra_wdata = 0;
  logic [RW-1:0] ra_row = '0;
  logic [CW-1:0] ra_col = '0;
  logic fill_start = 0, fill_value = 0;
  logic [CW-1:0] fill_x0 = '0, fill_x1 = '0;
  logic [RW-1:0] fill_y0 = '0, fill_y1 = '0;
  logic xfer_req = 0, pix_ready = 0;
  logic [RW-1:0] xfer_row = '0;
  logic ra_ready, rd_valid, rd_data, fill_busy, fill_done, pix_valid, pix_data, ser_empty;

  int total = 0;
  int bad = 0;
  logic refm [ROWS][COLS];

  always #4 clk = ~clk;

  fbuf_vram #(.ROW_W(RW), .COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ra_valid(ra_valid), .ra_ready(ra_ready), .ra_we(ra_we),
    .ra_row(ra_row), .ra_col(ra_col), .ra_wdata(ra_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .fill_start(fill_start), .fill_x0(fill_x0), .fill_y0(fill_y0),
    .fill_x1(fill_x1), .fill_y1(fill_y1), .fill_value(fill_value), .fill_busy(fill_busy),
    .fill_done(fill_done), .xfer_req(xfer_req), .xfer_row(xfer_row),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data), .ser_empty(ser_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int r, input int c, input logic b);
    ra_valid = 1; ra_we = 1; ra_row = RW'(r); ra_col = CW'(c); ra_wdata = b;
    @(negedge clk);
    ra_valid = 0; ra_we = 0;
    refm[r][c] = b;
  endtask

  task automatic rd_chk(input int r, input int c, input string req);
    ra_valid = 1; ra_we = 0; ra_row = RW'(r); ra_col = CW'(c);
    @(negedge clk);
    ra_valid = 0;
    if (!rd_valid) chk({req, " rd_valid"}, rd_valid, 1);
    chk(req, rd_data, refm[r][c]);
  endtask

  task automatic readback(input string req);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) rd_chk(r, c, req);
  endtask

  // drains an already loaded row; mode 1 gates ready with a pattern (R10)
  task automatic stream_out(input logic [COLS-1:0] exp, input int mode, input bit clobber,
                            input int row);
    int i = 0;
    int k = 0;
    while (i < COLS && k < 10 * COLS) begin
      pix_ready = (mode == 0) ? 1'b1 : ((k % 3) != 1);
      chk("R3 valid", pix_valid, 1);
      chk(mode ? "R10" : "R3", pix_data, exp[i]);
      if (clobber) begin
        ra_valid = 1; ra_we = 1; ra_row = RW'(row); ra_col = CW'(i); ra_wdata = ~exp[i];
      end
      @(negedge clk);
      if (clobber) begin
        ra_valid = 0; ra_we = 0; refm[row][i] = ~exp[i];
      end
      if (pix_ready) i++;
      k++;
    end
    pix_ready = 1;
    chk("R4 empty", ser_empty, 1);
    chk("R4 valid", pix_valid, 0);
    repeat (3) @(negedge clk);
    chk("R4 stays", ser_empty, 1);
    pix_ready = 0;
  endtask

  function automatic logic [COLS-1:0] row_of(input int r);
    logic [COLS-1:0] w;
    for (int c = 0; c < COLS; c++) w[c] = refm[r][c];
    return w;
  endfunction

  task automatic stream_chk(input int row, input int mode, input bit clobber);
    logic [COLS-1:0] exp = row_of(row);
    xfer_req = 1; xfer_row = RW'(row);
    @(negedge clk);
    xfer_req = 0;
    if (clobber) begin  // write on the load edge itself (R5)
      ra_valid = 1; ra_we = 1; ra_row = RW'(row); ra_col = '0; ra_wdata = ~exp[0];
    end
    @(negedge clk);
    ra_valid = 0; ra_we = 0;
    stream_out(exp, mode, clobber, row);
  endtask

  // xat: 0 = no transfer, else transfer sampled xat edges after start
  task automatic fill(input int x0, input int y0, input int x1, input int y1, input logic v,
                      input int xat, input int xrow, input bit poke);
    int xa = (x0 < x1) ? x0 : x1;
    int xb = (x0 < x1) ? x1 : x0;
    int ya = (y0 < y1) ? y0 : y1;
    int yb = (y0 < y1) ? y1 : y0;
    int n = (xb - xa + 1) * (yb - ya + 1);
    int cyc = 0;
    logic [COLS-1:0] snap;
    logic pk_old = 0;
    fill_x0 = CW'(x0); fill_y0 = RW'(y0); fill_x1 = CW'(x1); fill_y1 = RW'(y1);
    fill_value = v; fill_start = 1;
    @(negedge clk);
    fill_start = 0;
    chk("R7 busy", fill_busy, 1);
    chk("R9 ready", ra_ready, 0);
    if (xat > 0) begin
      snap = row_of(xrow);
      for (int c = 0; c < COLS; c++)
        if (xrow >= ya && xrow <= yb && c >= xa && c <= xb &&
            ((xrow - ya) * (xb - xa + 1) + (c - xa)) < xat) snap[c] = v;
    end
    while (!fill_done && cyc < 1000) begin
      if (poke && cyc == 1) begin
        pk_old = refm[ROWS-1][COLS-1];
        ra_valid = 1; ra_we = 1; ra_row = RW'(ROWS-1); ra_col = CW'(COLS-1); ra_wdata = ~pk_old;
        fill_start = 1; fill_x0 = '0; fill_x1 = CW'(COLS-1); fill_y0 = RW'(ROWS-1);
        fill_y1 = RW'(ROWS-1); fill_value = ~v;
      end
      if (xat > 0 && cyc == xat - 1) begin
        xfer_req = 1; xfer_row = RW'(xrow);
      end
      @(negedge clk);
      ra_valid = 0; ra_we = 0; fill_start = 0; xfer_req = 0;
      cyc++;
    end
    chk((xat > 0) ? "R8 cycles" : "R7 cycles", cyc, n + ((xat > 0) ? 1 : 0));
    chk("R7 busy fell", fill_busy, 0);
    @(negedge clk);
    chk("R7 done pulse", fill_done, 0);
    for (int r = ya; r <= yb; r++)
      for (int c = xa; c <= xb; c++) refm[r][c] = v;
    if (xat > 0) stream_out(snap, 0, 1'b0, xrow);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R7 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 pix_valid", pix_valid, 0);
    chk("R1 ser_empty", ser_empty, 1);
    chk("R1 fill_busy", fill_busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 ra_ready", ra_ready, 1);

    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wr(r, c, logic'(((r * 5 + c * 3 + (c >> 2)) % 3) == 0));
    readback("R2");

    stream_chk(3, 0, 1'b0);   // R3 R4
    stream_chk(5, 1, 1'b0);   // R10
    stream_chk(2, 0, 1'b1);   // R5
    readback("R2 after R5");

    fill(2, 1, 9, 3, 1'b1, 0, 0, 1'b0);     // R6 R7
    readback("R6 plain");
    fill(12, 6, 4, 5, 1'b0, 0, 0, 1'b0);    // R6 swapped corners
    fill(7, 7, 7, 7, 1'b1, 0, 0, 1'b0);     // R6 single cell
    readback("R6 swapped/single");
    fill(0, 1, 15, 3, 1'b0, 20, 2, 1'b0);   // R8 transfer mid-fill
    readback("R8 after");
    fill(1, 0, 3, 1, 1'b1, 0, 0, 1'b1);     // R9 pokes ignored
    readback("R9");
    fill(15, 7, 0, 0, 1'b1, 0, 0, 1'b0);    // R6 whole array
    readback("R6 full");
    stream_chk(7, 1, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule